// File: doc/BRIEF.md
# Burst Read Slave

This block answers read bursts on a memory-mapped bus with separate address and data channels. A requester offers a start byte address, a beat count minus one and a burst type on the address channel. Once that address handshake completes, the block streams the requested number of data beats out of an internal word store. Each beat comes with its own two-bit status code, and the final beat is flagged as last. The block holds only one read at a time and refuses new addresses until the current burst has been fully delivered.

The word store is a read-only array that is filled with a fixed arithmetic pattern at start-up, so a requester can tell from the data alone which word it received. A beat whose word index falls outside the store still goes out, with zero data and an error status. A burst that runs past the end of the store therefore mixes good and failed beats and still delivers its full length. The data channel follows a valid/ready handshake. A beat stays on the bus unchanged until the requester takes it.

Top module: `burst_read_slave`

## Requirements
- R1: While `rst` is high, `ar_ready` and `r_valid` are low. On the first rising edge after `rst` falls, `ar_ready` goes high.
- R2: An address is taken on a rising edge where `ar_valid` and `ar_ready` are both high. From that edge until the edge that completes the final beat, `ar_ready` stays low, so at most one read is active.
- R3: `r_valid` rises only on the edge right after an address handshake. It is never high before any address has been taken.
- R4: A burst delivers exactly `ar_len`+1 beats. `r_last` is high on the final beat only, so a burst with `ar_len`=0 has `r_last` high on its single beat.
- R5: While `r_valid` is high and `r_ready` is low, `r_valid` stays high and `r_data`, `r_resp` and `r_last` hold their values.
- R6: When `r_ready` is high on every cycle, the beats of a burst follow each other on consecutive cycles with no gap.
- R7: The word index is the byte address shifted right by log2(DATA_W/8). The low address bits are ignored. Word k of the store holds (k*0x01000193) XOR 0x5A5A5A5A, truncated to DATA_W bits.
- R8: Burst type 2'b00 repeats the first word index on every beat. Every other code adds one to the index per beat. The index wraps modulo 2^(ADDR_W-log2(DATA_W/8)).
- R9: A beat whose word index is DEPTH or above returns zero data with `r_resp`=2'b10. A beat within the store returns `r_resp`=2'b00.
- R10: An error beat does not end the burst. A burst that crosses the end of the store, or wraps back into it, delivers all its beats, each with its own status.
- R11: `ar_ready` returns high on the edge that completes the final beat, and a new address can be taken on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ar_valid | input | 1 | Address offer is valid |
| ar_ready | output | 1 | Block can take an address |
| ar_addr | input | ADDR_W | Start byte address |
| ar_len | input | LEN_W | Number of beats minus one |
| ar_burst | input | 2 | Burst type, 2'b00 fixed, others incrementing |
| r_valid | output | 1 | Data beat is on the bus |
| r_ready | input | 1 | Requester takes the beat |
| r_data | output | DATA_W | Beat data |
| r_resp | output | 2 | Beat status, 2'b00 good, 2'b10 error |
| r_last | output | 1 | Final beat of the burst |

## Verification
Every start index from 0 to 71 is read with a short burst. Lengths, burst types and unaligned low address bits rotate across these reads, so the sweep separates index decoding from offset bits and separates fixed bursts from incrementing ones. Each read uses one of four ready patterns: always ready, alternate stalls, double stalls, or a long stall on the first beat. These show whether a beat is held steady and whether back-to-back delivery works. Three long bursts cover the boundary cases. The first crosses the top of the store into error beats. The second starts near the top of the index space and wraps back into valid words. The third uses the largest length, which shows that error beats neither cut a burst short nor extend it.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [1:0] {
    RESP_GOOD = 2'b00,
    RESP_FAIL = 2'b10
  } beat_resp_e;

  localparam logic [1:0] BURST_HOLD = 2'b00;

  // Start-up contents of the word store; truncated by the user to its width.
  function automatic logic [63:0] fill_word(input int unsigned idx);
    return (64'(idx) * 64'h0000_0000_0100_0193) ^ 64'h5A5A_5A5A_5A5A_5A5A;
  endfunction

endpackage

// File: rtl/brs_word_store.sv
module brs_word_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int MEM_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              rd_zero,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  import brs_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(fill_word(i));
    end
  end

  // Registered read port; the zero path maps onto the output register reset.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      if (rd_zero) rd_data <= '0;
      else         rd_data <= mem[rd_idx];
    end
  end

endmodule

// File: rtl/brs_beat_addr.sv
module brs_beat_addr #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 8,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int IDX_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [1:0]        ar_burst,
  output logic [IDX_W-1:0]  fetch_idx,
  output logic              fetch_in_range,
  output logic              fetch_last
);
  import brs_pkg::*;

  localparam logic [IDX_W:0] DEPTH_L = (IDX_W + 1)'(DEPTH);

  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] step_idx;
  logic [IDX_W-1:0] ar_idx;
  logic [LEN_W-1:0] remain;
  logic             hold_q;
  logic             unused_offset_bits;

  assign unused_offset_bits = ^ar_addr[OFF_W-1:0];
  assign ar_idx   = ar_addr[ADDR_W-1:OFF_W];
  assign step_idx = hold_q ? cur_idx : cur_idx + 1'b1;

  always_comb begin
    if (load) begin
      fetch_idx  = ar_idx;
      fetch_last = (ar_len == '0);
    end else begin
      fetch_idx  = step_idx;
      fetch_last = (remain == LEN_W'(1));
    end
  end

  assign fetch_in_range = ({1'b0, fetch_idx} < DEPTH_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
      remain  <= '0;
      hold_q  <= 1'b0;
    end else if (load) begin
      cur_idx <= ar_idx;
      remain  <= ar_len;
      hold_q  <= (ar_burst == BURST_HOLD);
    end else if (advance) begin
      cur_idx <= step_idx;
      remain  <= remain - 1'b1;
    end
  end

  // R4: the controller never steps past the final beat.
  assert_no_early_advance_R4: assert property (@(posedge clk) disable iff (rst)
    advance |-> (remain != '0));

  // R2: a new address never arrives while a burst is stepping.
  assert_load_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !(load && advance));

endmodule

// File: rtl/brs_beat_ctrl.sv
module brs_beat_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       ar_valid,
  output logic       ar_ready,
  input  logic       r_ready,
  output logic       r_valid,
  output logic [1:0] r_resp,
  output logic       r_last,
  input  logic       fetch_in_range,
  input  logic       fetch_last,
  output logic       load,
  output logic       advance,
  output logic       rd_en
);
  import brs_pkg::*;

  logic       ar_ready_q;
  logic       r_valid_q;
  logic       r_last_q;
  beat_resp_e r_resp_q;
  logic       taken;
  logic       finish;

  assign load    = ar_valid && ar_ready_q;
  assign taken   = r_valid_q && r_ready;
  assign advance = taken && !r_last_q;
  assign finish  = taken && r_last_q;
  assign rd_en   = load || advance;

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_ready_q <= 1'b0;
      r_valid_q  <= 1'b0;
      r_last_q   <= 1'b0;
      r_resp_q   <= RESP_GOOD;
    end else begin
      ar_ready_q <= !load && (!r_valid_q || finish);
      if (rd_en)       r_valid_q <= 1'b1;
      else if (finish) r_valid_q <= 1'b0;
      if (rd_en) begin
        r_last_q <= fetch_last;
        r_resp_q <= fetch_in_range ? RESP_GOOD : RESP_FAIL;
      end
    end
  end

  assign ar_ready = ar_ready_q;
  assign r_valid  = r_valid_q;
  assign r_resp   = r_resp_q;
  assign r_last   = r_last_q;

  // R5: a waiting beat stays on the bus unchanged.
  assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (r_valid_q && !r_ready) |=> (r_valid_q && $stable(r_resp_q) && $stable(r_last_q)));

  // R2: no address is accepted while a beat is outstanding.
  assert_single_active_R2: assert property (@(posedge clk) disable iff (rst)
    r_valid_q |-> !ar_ready_q);

  // R3: data appears only after an address handshake.
  assert_data_after_addr_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(r_valid_q) |-> $past(load));

endmodule

// File: rtl/burst_read_slave.sv
module burst_read_slave #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 8,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int IDX_W  = ADDR_W - OFF_W,
  localparam int MEM_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [1:0]        ar_burst,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);

  logic             load;
  logic             advance;
  logic             rd_en;
  logic [IDX_W-1:0] fetch_idx;
  logic             fetch_in_range;
  logic             fetch_last;

  brs_beat_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .ar_valid       (ar_valid),
    .ar_ready       (ar_ready),
    .r_ready        (r_ready),
    .r_valid        (r_valid),
    .r_resp         (r_resp),
    .r_last         (r_last),
    .fetch_in_range (fetch_in_range),
    .fetch_last     (fetch_last),
    .load           (load),
    .advance        (advance),
    .rd_en          (rd_en)
  );

  brs_beat_addr #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .LEN_W  (LEN_W)
  ) u_addr (
    .clk            (clk),
    .rst            (rst),
    .load           (load),
    .advance        (advance),
    .ar_addr        (ar_addr),
    .ar_len         (ar_len),
    .ar_burst       (ar_burst),
    .fetch_idx      (fetch_idx),
    .fetch_in_range (fetch_in_range),
    .fetch_last     (fetch_last)
  );

  brs_word_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk     (clk),
    .rd_en   (rd_en),
    .rd_zero (!fetch_in_range),
    .rd_idx  (fetch_idx[MEM_AW-1:0]),
    .rd_data (r_data)
  );

  // Beat tally used only by the length check below.
  logic [LEN_W:0]   beat_cnt;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt <= '0;
      len_q    <= '0;
    end else if (ar_valid && ar_ready) begin
      beat_cnt <= '0;
      len_q    <= ar_len;
    end else if (r_valid && r_ready) begin
      beat_cnt <= beat_cnt + 1'b1;
    end
  end

  // R4, R10: the flagged last beat is exactly beat number len.
  assert_full_length_R4: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && r_last) |-> (beat_cnt == {1'b0, len_q}));

  // R9: an error beat carries zero data.
  assert_fail_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_resp == 2'b10) |-> (r_data == '0));

  // R5: data is held while the requester stalls.
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> $stable(r_data));

endmodule

// File: tb/burst_read_slave_tb.sv
`timescale 1ns/1ps
module burst_read_slave_tb;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;
  localparam int LEN_W  = 8;
  localparam int SPAN   = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ar_valid = 1'b0;
  logic              ar_ready;
  logic [ADDR_W-1:0] ar_addr = '0;
  logic [LEN_W-1:0]  ar_len = '0;
  logic [1:0]        ar_burst = 2'b01;
  logic              r_valid;
  logic              r_ready = 1'b0;
  logic [DATA_W-1:0] r_data;
  logic [1:0]        r_resp;
  logic              r_last;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  burst_read_slave #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .LEN_W  (LEN_W)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .ar_valid (ar_valid),
    .ar_ready (ar_ready),
    .ar_addr  (ar_addr),
    .ar_len   (ar_len),
    .ar_burst (ar_burst),
    .r_valid  (r_valid),
    .r_ready  (r_ready),
    .r_data   (r_data),
    .r_resp   (r_resp),
    .r_last   (r_last)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_data(input int idx);
    logic [DATA_W-1:0] k = DATA_W'(idx);
    if (idx >= DEPTH) return '0;
    return (k * 32'h0100_0193) ^ 32'h5A5A_5A5A;
  endfunction

  function automatic bit stall(input int mode, input int b, input int w);
    return (mode == 1 && w == 0 && (b % 2) == 1) ||
           (mode == 2 && w < 2 && (b % 3) == 0) ||
           (mode == 3 && w < 3 && b == 0);
  endfunction

  task automatic do_read(input int idx, input int off, input int len,
                         input logic [1:0] bt, input int mode);
    int cur = idx;
    int waits = 0;
    logic [DATA_W-1:0] s_data;
    logic [1:0]        s_resp;
    logic              s_last;
    ar_valid = 1'b1;
    ar_addr  = ADDR_W'(idx * 4 + off);
    ar_len   = LEN_W'(len);
    ar_burst = bt;
    while (!ar_ready && waits < 8) begin
      @(negedge clk);
      waits++;
    end
    @(negedge clk);
    ar_valid = 1'b0;
    chk(r_valid === 1'b1, "R3 first beat one cycle after address", 64'(r_valid), 64'd1);
    for (int b = 0; b <= len; b++) begin
      int w = 0;
      while (stall(mode, b, w)) begin
        r_ready = 1'b0;
        s_data = r_data; s_resp = r_resp; s_last = r_last;
        @(negedge clk);
        chk(r_valid === 1'b1, "R5 valid held", 64'(r_valid), 64'd1);
        chk(r_data === s_data && r_resp === s_resp && r_last === s_last,
            "R5 beat held", {r_data, 29'd0, r_resp, r_last}, {s_data, 29'd0, s_resp, s_last});
        w++;
      end
      r_ready = 1'b1;
      chk(r_valid === 1'b1, "R6 beat present", 64'(r_valid), 64'd1);
      chk(ar_ready === 1'b0, "R2 address refused in burst", 64'(ar_ready), 64'd0);
      chk(r_data === exp_data(cur), "R7 data", 64'(r_data), 64'(exp_data(cur)));
      chk(r_resp === ((cur < DEPTH) ? 2'b00 : 2'b10), "R9 resp", 64'(r_resp),
          64'((cur < DEPTH) ? 2'b00 : 2'b10));
      chk(r_last === (b == len), "R4 last flag", 64'(r_last), 64'(b == len));
      @(negedge clk);
      if (bt != 2'b00) cur = (cur + 1) % SPAN;
    end
    r_ready = 1'b0;
    chk(r_valid === 1'b0, "R4 no extra beat", 64'(r_valid), 64'd0);
    chk(ar_ready === 1'b1, "R11 ready after final beat", 64'(ar_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ar_ready === 1'b0 && r_valid === 1'b0, "R1 reset outputs",
        {62'd0, ar_ready, r_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(ar_ready === 1'b1, "R1 ready after reset", 64'(ar_ready), 64'd1);
    repeat (2) begin
      @(negedge clk);
      chk(r_valid === 1'b0, "R3 no data without address", 64'(r_valid), 64'd0);
    end

    // R7, R8: sweep every start index across the store edge.
    for (int s = 0; s < 72; s++) begin
      logic [1:0] bt = (s % 3 == 0) ? 2'b00 : ((s % 3 == 1) ? 2'b01 : 2'b11);
      do_read(s, s % 4, s % 6, bt, s % 4);
      if (s % 5 == 0) begin
        @(negedge clk);
        chk(r_valid === 1'b0, "R3 idle gap", 64'(r_valid), 64'd0);
      end
    end

    // R10: crosses the top of the store.
    do_read(56, 0, 15, 2'b01, 2);
    // R8, R10: wraps from the top of the index space back into the store.
    do_read(SPAN - 4, 3, 7, 2'b01, 1);
    // R4, R6, R10: longest burst, always ready.
    do_read(0, 0, 255, 2'b01, 0);
    // R4: single beat, fixed, out of range.
    do_read(200, 1, 0, 2'b00, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule